// File: doc/BRIEF.md
# Crystal Drift Trim Unit

This block sits between a 32 kHz tick source and the seconds logic of a real-time clock. It divides the ticks into one-second pulses and, on selected seconds, shortens or lengthens the division so that a crystal running fast or slow can be corrected. Software supplies one byte that carries three fields: a step code, a direction and a choice between a short and a long correction window.

On every window boundary the unit moves the prescaler's terminal count by twice the decoded step count. Adding pulses makes that second shorter and removing pulses makes it longer. With the default short window of 20 s, one step is worth about 3051 ppb. With the default long window of 60 s, one step is worth about 1017 ppb.

A new byte is parked in a pending register and raises a busy flag. The setting takes effect at the next second boundary, which also clears the flag. Any write that arrives while the flag is high is dropped.

Top module: `clk_trim`

## Requirements
- R1: After reset `busy` and `sec_tick` are low, and every second lasts exactly NOM tick cycles until a setting is written.
- R2: `sec_tick` is a one-cycle pulse, one clock after the last tick of a second. A second is counted only in cycles where `tick_in` is high, so clock cycles without `tick_in` stretch it.
- R3: The unit counts second indices from 0 to LONG_WIN-1 and wraps, starting from 0 at reset. Only seconds whose index is a multiple of the window length are corrected. Byte bit 7 set selects LONG_WIN and clear selects SHORT_WIN, and all other seconds last NOM.
- R4: A step code (byte bits 5:0) of zero gives no correction in either direction.
- R5: With bit 6 clear (add), the step count is code-1, and a correction second lasts NOM - 2*(code-1) ticks.
- R6: With bit 6 set (remove), the step count is ((~code) & 6'h3F) + 1, and a correction second lasts NOM + 2*steps ticks.
- R7: A write taken while `busy` is low raises `busy` on the next clock. The new setting governs the second that begins at the next `sec_tick`, and `busy` falls in the same cycle as that pulse.
- R8: A write while `busy` is high is ignored and leaves the pending setting unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | 32 kHz tick enable, one clock wide per tick |
| wr_en | input | 1 | Write strobe for the correction byte |
| wr_data | input | 8 | Correction byte: bit 7 window, bit 6 direction, bits 5:0 step code |
| sec_tick | output | 1 | One-second pulse |
| busy | output | 1 | High while a written setting waits for a second boundary |

## Verification
The bench measures the length of each second between pulses. It checks the extremes of both codes (add code 0x3F gives -124 and remove code 0x02 gives +124), codes 0x00 and 0x01 that must give no change, and the remove code 0x3F worth a single step. A decoder that used the wrong bias or forgot the complement would miss these lengths by whole steps.

Long-window runs check that seconds at multiples of the short window stay nominal. A unit that ignored bit 7 would shorten those seconds.

Each setting is followed at once by a second, different write. If the unit accepted writes while busy, the corrected second would take the wrong length. If busy were released at the wrong moment, the flag would still be high at the boundary pulse.

A gap in `tick_in` shows whether the prescaler is stepped by the system clock instead of by the tick enable.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;

  // Correction byte layout: window select, direction, step code.
  typedef struct packed {
    logic       long_win;
    logic       remove;
    logic [5:0] code;
  } trim_cfg_t;

  localparam int STEP_W = 7;

endpackage

// File: rtl/clk_trim_decode.sv
module clk_trim_decode
  import clk_trim_pkg::*;
(
  input  trim_cfg_t         cfg,
  output logic [STEP_W-1:0] steps,
  output logic              remove
);

  always_comb begin
    remove = cfg.remove;
    if (cfg.code == '0) begin
      steps = '0;
    end else if (cfg.remove) begin
      steps = {1'b0, ~cfg.code} + 7'd1;
    end else begin
      steps = {1'b0, cfg.code} - 7'd1;
    end
  end

endmodule

// File: rtl/clk_trim_window.sv
module clk_trim_window #(
  parameter  int SHORT_WIN = 20,
  parameter  int LONG_WIN  = 60,
  localparam int IW        = $clog2(LONG_WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          long_win,
  output logic [IW-1:0] idx,
  output logic          is_win
);

  logic [IW-1:0] idx_q, idx_n;

  always_comb begin
    idx_n = idx_q;
    if (adv) begin
      if (idx_q == IW'(LONG_WIN - 1)) idx_n = '0;
      else                            idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (adv) idx_q <= idx_n;
  end

  always_comb begin
    if (long_win) is_win = (idx_q == '0);
    else          is_win = ((int'(idx_q) % SHORT_WIN) == 0);
  end

  assign idx = idx_q;

endmodule

// File: rtl/clk_trim_presc.sv
module clk_trim_presc #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic [CW-1:0] term,
  output logic          wrap
);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    wrap  = tick_in && (cnt_q >= term - 1'b1);
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_in) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/clk_trim.sv
module clk_trim
  import clk_trim_pkg::*;
#(
  parameter int NOM       = 32768,
  parameter int SHORT_WIN = 20,
  parameter int LONG_WIN  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       sec_tick,
  output logic       busy
);

  localparam int MAX_ADJ = 2 * ((1 << 6) - 1);
  localparam int CW      = $clog2(NOM + MAX_ADJ + 1);
  localparam int IW      = $clog2(LONG_WIN);
  localparam logic [CW-1:0] NOM_C = CW'(NOM);

  trim_cfg_t pend_q, pend_n;
  trim_cfg_t act_q, act_n;
  logic      busy_q, busy_n;
  logic      tick_q;
  logic      accept, wrap, is_win, remove;
  logic [STEP_W-1:0] steps;
  logic [IW-1:0]     win_idx;
  logic [CW-1:0]     adj, term;

  assign accept = wr_en && !busy_q;

  always_comb begin
    pend_n = accept ? trim_cfg_t'(wr_data) : pend_q;
    act_n  = (wrap && busy_q) ? pend_q : act_q;
    busy_n = busy_q;
    if (accept)    busy_n = 1'b1;
    else if (wrap) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      busy_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (accept)         pend_q <= pend_n;
      if (wrap && busy_q) act_q  <= act_n;
      busy_q <= busy_n;
      tick_q <= wrap;
    end
  end

  clk_trim_decode u_decode (
    .cfg    (act_q),
    .steps  (steps),
    .remove (remove)
  );

  clk_trim_window #(
    .SHORT_WIN (SHORT_WIN),
    .LONG_WIN  (LONG_WIN)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (wrap),
    .long_win (act_q.long_win),
    .idx      (win_idx),
    .is_win   (is_win)
  );

  always_comb begin
    adj = CW'({steps, 1'b0});
    if (!is_win)     term = NOM_C;
    else if (remove) term = NOM_C + adj;
    else             term = NOM_C - adj;
  end

  clk_trim_presc #(
    .CW (CW)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .term    (term),
    .wrap    (wrap)
  );

  assign sec_tick = tick_q;
  assign busy     = busy_q;

endmodule

// File: rtl/clk_trim_chk.sv
module clk_trim_chk
  import clk_trim_pkg::*;
#(
  parameter int LONG_WIN = 60,
  parameter int IW       = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_in,
  input logic          wr_en,
  input logic          busy,
  input logic          sec_tick,
  input trim_cfg_t     pend,
  input logic [IW-1:0] idx
);

  // R7: an accepted write raises busy on the next clock
  a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);

  // R7: busy drops only together with the second pulse
  a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sec_tick);

  // R8: a write during busy leaves the pending setting alone
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(pend));

  // R2: a second ends only on a cycle carrying a tick
  a_r2_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(tick_in));

  // R2: the second pulse is one cycle wide
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R3: the second index stays inside the long window
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(LONG_WIN - 1));

endmodule

bind clk_trim clk_trim_chk #(
  .LONG_WIN (LONG_WIN),
  .IW       (IW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_in  (tick_in),
  .wr_en    (wr_en),
  .busy     (busy),
  .sec_tick (sec_tick),
  .pend     (pend_q),
  .idx      (win_idx)
);

// File: tb/clk_trim_tb.sv
module clk_trim_tb;

  localparam int NOM   = 200;
  localparam int SHORT = 4;
  localparam int LONG  = 12;
  localparam int NV    = 9;

  // stimulus byte and expected change of a correction second, in ticks
  localparam logic [7:0] VDATA [NV] = '{8'h00, 8'h05, 8'h85, 8'h01, 8'h3F,
                                        8'h7F, 8'h42, 8'hC0, 8'hFB};
  localparam int VDELTA [NV] = '{0, -8, -8, 0, -124, 2, 124, 0, 10};

  logic       clk, rst_n, tick_in, wr_en;
  logic [7:0] wr_data;
  logic       sec_tick, busy;

  int total, bad, cyc, last_cyc, ntick, len;

  clk_trim #(.NOM(NOM), .SHORT_WIN(SHORT), .LONG_WIN(LONG)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sec_tick (sec_tick),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!sec_tick) @(negedge clk);
    ntick++;
    len      = cyc - last_cyc;
    last_cyc = cyc;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string req;
    int    cur, per, s, exp_len;
    bit    got_w, got_p, first;
    total = 0; bad = 0; cyc = 0; last_cyc = 0; ntick = 0; len = 0;
    rst_n = 1'b0; tick_in = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(sec_tick == 1'b0, "R1 sec_tick after reset", sec_tick, 0);

    // R1: nominal seconds before any write (second 4 is a short-window index)
    wait_tick();
    for (int k = 1; k <= 5; k++) begin
      wait_tick();
      check(len == NOM, "R1 nominal second", len, NOM);
    end
    @(negedge clk);
    check(sec_tick == 1'b0, "R2 pulse width", sec_tick, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wait_tick();
      cur = ntick;
      do_write(VDATA[v]);
      check(busy == 1'b1, "R7 busy after write", busy, 1);
      do_write(VDATA[v] ^ 8'h0A);  // dropped while busy
      check(busy == 1'b1, "R8 busy held", busy, 1);
      per   = VDATA[v][7] ? LONG : SHORT;
      got_w = 1'b0; got_p = 1'b0; first = 1'b1;
      if (VDATA[v][5:0] == 6'd0)  req = "R4";
      else if (VDATA[v][6])       req = "R6";
      else                        req = "R5";
      while (!(got_w && got_p)) begin
        wait_tick();
        if (first) begin
          check(busy == 1'b0, "R7 busy cleared at boundary", busy, 0);
          first = 1'b0;
        end
        s = ntick - 1;
        if (s > cur) begin
          if ((s % per) == 0) begin
            exp_len = NOM + VDELTA[v];
            got_w   = 1'b1;
            check(len == exp_len, {req, " +R8 correction second"}, len, exp_len);
          end else begin
            exp_len = NOM;
            got_p   = 1'b1;
            check(len == exp_len, "R3 uncorrected second", len, exp_len);
          end
        end
      end
    end

    // R2: cycles without tick_in stretch the second
    wait_tick();
    do_write(8'h00);
    wait_tick();
    repeat (9) @(negedge clk);
    tick_in = 1'b0;
    repeat (7) @(negedge clk);
    tick_in = 1'b1;
    wait_tick();
    check(len == NOM + 7, "R2 tick gating", len, NOM + 7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule